// File: doc/BRIEF.md
# Composite Clock Slice

This block generates one output clock from a bank of up to eight source clocks. The path has four stages. A glitch-free source selector comes first. A pre-divider with ratios 1 to 8 follows it, then a post-divider with ratios 1 to 64 that is clocked by the pre-divider output. A clock gate comes last. One 32-bit control register holds the whole configuration. A write strobe replaces the full register. A second strobe touches only the two ratio fields, so software can retune the frequency without disturbing the source or gate setting. The register can always be read back.

Each ratio field holds the divisor minus one. The output frequency is source / (pre+1) / (post+1). A stage set to ratio 1 passes its input clock straight through. For odd ratios the high phase is the shorter one. Every configuration change reaches the output without a runt pulse.

The source selector is a small state machine in the register clock domain. SW_RAISE is the reset state, and it enables source 0. In SW_RAISE the machine holds the chosen source's enable and moves to SW_IDLE once that source acknowledges. In SW_IDLE it keeps the current source and moves to SW_DROP when the select field differs from the live source. In SW_DROP all enables are low. Once no source acknowledges, it latches the newest select value and moves to SW_RAISE. Each source has a two-flop synchronizer in its own domain, followed by a falling-edge enable flop. The acknowledges return through a two-flop synchronizer in the register domain.

Top module: `clk_slice`

## Requirements
- R1: After reset the register reads 0x0000_0000: source 0, both ratios 1, gate off. clk_out stays low.
- R2: A cycle with wr_en high replaces all 32 register bits with wr_data. This includes the spare bits, and rd_data shows the new value after that register-clock edge.
- R3: A cycle with div_wr high and wr_en low changes only bits 18:16 and 5:0 (mask 0x0007_003F) and leaves all other bits unchanged. When both strobes are high, wr_en wins.
- R4: Bits 26:24 pick src_clk[n]. With both ratio fields 0 and the gate on, clk_out has the period and high time of that source.
- R5: Bits 18:16 set the pre-divider ratio P = value+1. With the post ratio 1, the period is P source periods and the high time is floor(P/2) source periods when P>1.
- R6: Bits 5:0 set the post ratio Q = value+1, applied to the pre-divider output. The period is P*Q source periods and the high time is floor(Q/2)*P source periods when Q>1.
- R7: Bit 28 is the gate. When it is 0, clk_out is held low. Turning it on or off produces no pulse narrower than the configured high or low time.
- R8: A source change stops the old clock low before the new one starts. At most one source is acknowledged at any time, and no pulse is narrower than the faster source's half period.
- R9: A divider loads a new ratio only at the end of its current output period. A ratio change mid-period gives no pulse narrower than the smaller of the old and new high and low times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | NSRC (8) | Source clock bank |
| reg_clk | input | 1 | Register and selector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full register write strobe |
| div_wr | input | 1 | Ratio-fields-only write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
rd_data is due one register-clock edge after a strobe, so the bench checks it at the following falling edge. Every clock-side effect passes through two synchronizer flops in the receiving domain. It then waits for the end of the running divider period, and for a source change it also waits for the selector handshake. Because of this, the bench waits a fixed window after each write that is longer than the worst such chain for the tested configuration. Only then does it time whole periods from rising edge to rising edge. A free-running monitor records the narrowest high and low pulses across gate, source and ratio changes, so runts are caught even inside the settling window.

// File: rtl/clk_slice_pkg.sv
package clk_slice_pkg;

    localparam int CTRL_W   = 32;
    localparam int SEL_LSB  = 24;
    localparam int GATE_BIT = 28;
    localparam int PRE_LSB  = 16;
    localparam int PRE_W    = 3;
    localparam int POST_LSB = 0;
    localparam int POST_W   = 6;

    localparam logic [CTRL_W-1:0] DIV_MASK =
        (((CTRL_W'(1) << PRE_W) - CTRL_W'(1)) << PRE_LSB) |
        (((CTRL_W'(1) << POST_W) - CTRL_W'(1)) << POST_LSB);

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_DROP,
        SW_RAISE
    } sw_state_e;

endpackage

// File: rtl/clk_slice_sync.sv
module clk_slice_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/clk_slice_src_switch.sv
module clk_slice_src_switch
    import clk_slice_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic            reg_clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic [SW-1:0]   want_sel,
    output logic            mclk
);

    sw_state_e       st_q, st_n;
    logic [SW-1:0]   sel_q, sel_n;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] ack;
    logic [NSRC-1:0] on_vec;
    logic [NSRC-1:0] gated;

    // next-state decode
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            SW_IDLE:  if (want_sel != sel_q) st_n = SW_DROP;
            SW_DROP:  if (ack == '0)         st_n = SW_RAISE;
            SW_RAISE: if (ack[sel_q])        st_n = SW_IDLE;
            default:                         st_n = SW_IDLE;
        endcase
    end

    always_comb begin
        sel_n = sel_q;
        if (st_q == SW_DROP && st_n == SW_RAISE) sel_n = want_sel;
    end

    // state register
    always_ff @(posedge reg_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SW_RAISE;
            sel_q <= '0;
        end else begin
            st_q  <= st_n;
            sel_q <= sel_n;
        end
    end

    // registered enable outputs
    always_ff @(posedge reg_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= '0;
            if (st_n != SW_DROP) en_q[sel_n] <= 1'b1;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic req_s;
        logic on_q;

        clk_slice_sync #(.W(1)) u_req (
            .clk   (src_clk[i]),
            .rst_n (rst_n),
            .d     (en_q[i]),
            .q     (req_s)
        );

        always_ff @(negedge src_clk[i] or negedge rst_n) begin
            if (!rst_n) on_q <= 1'b0;
            else        on_q <= req_s;
        end

        assign on_vec[i] = on_q;
        assign gated[i]  = src_clk[i] & on_q;
    end

    clk_slice_sync #(.W(NSRC)) u_ack (
        .clk   (reg_clk),
        .rst_n (rst_n),
        .d     (on_vec),
        .q     (ack)
    );

    assign mclk = |gated;

    // R8
    one_src_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(ack));

endmodule

// File: rtl/clk_slice_int_div.sv
module clk_slice_int_div #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_m1,
    output logic         clk_o
);

    logic [W-1:0] lim_s, lim_q, lim_n;
    logic [W-1:0] cnt_q, cnt_n;
    logic [W:0]   half_n;
    logic         out_q, out_n;

    clk_slice_sync #(.W(W)) u_cfg (
        .clk   (clk_i),
        .rst_n (rst_n),
        .d     (ratio_m1),
        .q     (lim_s)
    );

    always_comb begin
        if (cnt_q == lim_q) begin
            cnt_n = '0;
            lim_n = lim_s;
        end else begin
            cnt_n = cnt_q + {{(W-1){1'b0}}, 1'b1};
            lim_n = lim_q;
        end
        half_n = ({1'b0, lim_n} + {{W{1'b0}}, 1'b1}) >> 1;
        out_n  = ({1'b0, cnt_n} < half_n);
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            lim_q <= lim_n;
            out_q <= out_n;
        end
    end

    assign clk_o = (lim_q == '0) ? clk_i : out_q;

    // R9
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        cnt_q <= lim_q);

    // R9
    lim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cnt_q != lim_q) |=> $stable(lim_q));

endmodule

// File: rtl/clk_slice_out_gate.sv
module clk_slice_out_gate (
    input  logic clk_i,
    input  logic rst_n,
    input  logic en,
    output logic clk_o
);

    logic en_s;
    logic pass_q;

    clk_slice_sync #(.W(1)) u_en (
        .clk   (clk_i),
        .rst_n (rst_n),
        .d     (en),
        .q     (en_s)
    );

    // enable may only move while the clock is low
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= en_s;
    end

    assign clk_o = clk_i & pass_q;

endmodule

// File: rtl/clk_slice.sv
module clk_slice
    import clk_slice_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0]   src_clk,
    input  logic              reg_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              div_wr,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              clk_out
);

    localparam int SELW = $clog2(NSRC);

    logic [CTRL_W-1:0] ctrl_q;
    logic mclk, pclk, dclk;

    always_ff @(posedge reg_clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_en)  ctrl_q <= wr_data;
        else if (div_wr) ctrl_q <= (ctrl_q & ~DIV_MASK) | (wr_data & DIV_MASK);
    end

    assign rd_data = ctrl_q;

    clk_slice_src_switch #(.NSRC(NSRC)) u_sw (
        .reg_clk  (reg_clk),
        .rst_n    (rst_n),
        .src_clk  (src_clk),
        .want_sel (ctrl_q[SEL_LSB +: SELW]),
        .mclk     (mclk)
    );

    clk_slice_int_div #(.W(PRE_W)) u_pre (
        .clk_i    (mclk),
        .rst_n    (rst_n),
        .ratio_m1 (ctrl_q[PRE_LSB +: PRE_W]),
        .clk_o    (pclk)
    );

    clk_slice_int_div #(.W(POST_W)) u_post (
        .clk_i    (pclk),
        .rst_n    (rst_n),
        .ratio_m1 (ctrl_q[POST_LSB +: POST_W]),
        .clk_o    (dclk)
    );

    clk_slice_out_gate u_gate (
        .clk_i (dclk),
        .rst_n (rst_n),
        .en    (ctrl_q[GATE_BIT]),
        .clk_o (clk_out)
    );

    // R2
    wr_back_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    // R3
    div_keep_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (div_wr && !wr_en) |=> ((rd_data & ~DIV_MASK) == ($past(rd_data) & ~DIV_MASK)));

endmodule

// File: tb/test_clk_slice.sv
`timescale 1ns/1ps
module test_clk_slice;

    logic [7:0]  src_clk;
    logic        reg_clk;
    logic        rst_n;
    logic        wr_en;
    logic        div_wr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        clk_out;

    int n_chk  = 0;
    int n_fail = 0;
    int rises  = 0;
    realtime last_r = 0.0, last_f = 0.0;
    realtime min_hi = 1.0e9, min_lo = 1.0e9;

    clk_slice i_clk_slice (
        .src_clk (src_clk),
        .reg_clk (reg_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .div_wr  (div_wr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_out (clk_out)
    );

    // source n has half period 5+n ns
    for (genvar g = 0; g < 8; g++) begin : g_src
        initial begin
            src_clk[g] = 1'b0;
            #(0.3 * g);
            forever #(5 + g) src_clk[g] = ~src_clk[g];
        end
    end

    initial begin
        reg_clk = 1'b0;
        forever #5 reg_clk = ~reg_clk;
    end

    // pulse-width monitor
    always @(posedge clk_out) begin
        rises++;
        if ($realtime - last_f < min_lo) min_lo = $realtime - last_f;
        last_r = $realtime;
    end
    always @(negedge clk_out) begin
        if ($realtime - last_r < min_hi) min_hi = $realtime - last_r;
        last_f = $realtime;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #1ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic chk_val(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_time(string req, realtime act, realtime exp);
        n_chk++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            n_fail++;
            $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
        end
    endtask

    task automatic chk_min(string req, realtime act, realtime lim);
        n_chk++;
        if (act < lim - 0.01) begin
            n_fail++;
            $display("FAIL %s: actual %0.2f expected >= %0.2f", req, act, lim);
        end
    endtask

    function automatic logic [31:0] cfg(int sel, int p, int q, bit g);
        logic [31:0] v;
        v = '0;
        v[26:24] = 3'(sel);
        v[18:16] = 3'(p - 1);
        v[5:0]   = 6'(q - 1);
        v[28]    = g;
        return v;
    endfunction

    task automatic put(logic [31:0] d, bit full, bit divonly);
        @(negedge reg_clk);
        wr_en   = full;
        div_wr  = divonly;
        wr_data = d;
        @(negedge reg_clk);
        wr_en   = 1'b0;
        div_wr  = 1'b0;
    endtask

    task automatic measure(output realtime per, output realtime hi);
        realtime r0, f0, r1;
        @(posedge clk_out); r0 = $realtime;
        @(negedge clk_out); f0 = $realtime;
        @(posedge clk_out); r1 = $realtime;
        per = r1 - r0;
        hi  = f0 - r0;
    endtask

    task automatic clear_stats();
        min_hi = 1.0e9;
        min_lo = 1.0e9;
    endtask

    task automatic run_cfg(string req, int sel, int p, int q);
        realtime per, hi, t, ehi;
        put(cfg(sel, p, q, 1'b1), 1'b1, 1'b0);
        #4000;
        t   = 2.0 * (5 + sel);
        ehi = (q > 1) ? (q / 2) * p * t : ((p > 1) ? (p / 2) * t : t / 2.0);
        measure(per, hi);
        chk_time({req, " period"}, per, p * q * t);
        chk_time({req, " high"}, hi, ehi);
    endtask

    task automatic t_reset();
        chk_val("R1 reset value", rd_data, 32'h0000_0000);
        rises = 0;
        #800;
        chk_val("R1 no output edge", 32'(rises), 32'd0);
        chk_val("R1 output low", {31'b0, clk_out}, 32'd0);
    endtask

    task automatic t_regs();
        put(32'hA5A5_5A5A, 1'b1, 1'b0);
        chk_val("R2 full write", rd_data, 32'hA5A5_5A5A);
        put(32'hFFFF_FFFF, 1'b0, 1'b1);
        chk_val("R3 ratio-only write", rd_data,
                (32'hA5A5_5A5A & ~32'h0007_003F) | 32'h0007_003F);
        put(32'h1234_5678, 1'b1, 1'b1);
        chk_val("R3 full write wins", rd_data, 32'h1234_5678);
        put(32'h0000_0000, 1'b0, 1'b1);
        chk_val("R3 spare bits kept", rd_data, 32'h1230_5640);
    endtask

    task automatic t_bypass();
        run_cfg("R4 src0", 0, 1, 1);
        run_cfg("R4 src6", 6, 1, 1);
    endtask

    task automatic t_prediv();
        run_cfg("R5 pre3", 2, 3, 1);
        run_cfg("R5 pre8", 2, 8, 1);
    endtask

    task automatic t_cascade();
        run_cfg("R6 pre2 post5", 1, 2, 5);
        run_cfg("R6 post4", 3, 1, 4);
    endtask

    task automatic t_gate();
        realtime per, hi;
        clear_stats();
        put(cfg(3, 1, 4, 1'b0), 1'b1, 1'b0);
        #1000;
        rises = 0;
        #1000;
        chk_val("R7 gate off no edges", 32'(rises), 32'd0);
        chk_val("R7 gate off low", {31'b0, clk_out}, 32'd0);
        put(cfg(3, 1, 4, 1'b1), 1'b1, 1'b0);
        #2000;
        measure(per, hi);
        chk_time("R7 gate on period", per, 64.0);
        chk_min("R7 no runt high", min_hi, 32.0);
        chk_min("R7 no runt low", min_lo, 32.0);
    endtask

    task automatic t_switch();
        realtime per, hi;
        run_cfg("R8 start src0", 0, 1, 1);
        clear_stats();
        put(cfg(7, 1, 1, 1'b1), 1'b1, 1'b0);
        #2000;
        measure(per, hi);
        chk_time("R8 to src7 period", per, 24.0);
        chk_min("R8 0->7 min high", min_hi, 5.0);
        chk_min("R8 0->7 min low", min_lo, 5.0);
        clear_stats();
        put(cfg(0, 1, 1, 1'b1), 1'b1, 1'b0);
        #2000;
        measure(per, hi);
        chk_time("R8 to src0 period", per, 10.0);
        chk_min("R8 7->0 min high", min_hi, 5.0);
        chk_min("R8 7->0 min low", min_lo, 5.0);
    endtask

    task automatic t_reload();
        realtime per, hi;
        run_cfg("R9 start post8", 4, 1, 8);
        @(posedge clk_out);
        #30;
        clear_stats();
        put(cfg(0, 1, 2, 1'b0), 1'b0, 1'b1);
        #3000;
        measure(per, hi);
        chk_time("R9 post2 period", per, 36.0);
        chk_min("R9 post min high", min_hi, 18.0);
        chk_min("R9 post min low", min_lo, 18.0);
        run_cfg("R9 start pre5", 4, 5, 1);
        @(posedge clk_out);
        #20;
        clear_stats();
        put(cfg(0, 2, 1, 1'b0), 1'b0, 1'b1);
        #3000;
        measure(per, hi);
        chk_time("R9 pre2 period", per, 36.0);
        chk_min("R9 pre min high", min_hi, 18.0);
        chk_min("R9 pre min low", min_lo, 18.0);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        div_wr  = 1'b0;
        wr_data = '0;
        #103;
        rst_n = 1'b1;
        #200;
        t_reset();
        t_regs();
        t_bypass();
        t_prediv();
        t_cascade();
        t_gate();
        t_switch();
        t_reload();
        summary();
        $finish;
    end

endmodule